// File: doc/BRIEF.md
# Block PIO Byte/Word Packer

This block sits between a byte-wide stream and a 32-bit data-port register and moves whole blocks of data by programmed I/O. In the write direction it takes bytes from an upstream valid/ready stream, packs them into 32-bit words, and emits each finished word to the port with a one-cycle write strobe. In the read direction it fetches 32-bit words from the port with a one-cycle read strobe and hands out their bytes, lowest lane first, on a downstream valid/ready stream.

A transfer is opened with a start pulse that latches the direction, the block length in bytes (1 to 2048) and the number of blocks. Before each block the block waits for a per-direction readiness flag, "read data present" or "write room present". Once a block has begun it runs to its end without looking at the flag again. When the last block is finished a one-cycle done pulse is raised and the block goes idle.

Top module: `pio_word_packer`

## Requirements
- R1: Byte k of a port word (k = 0..3) occupies bits 8k+7:8k, in both directions. Byte 0 is the first byte of the stream.
- R2: In write mode, a port write strobe is raised in the cycle after each fourth accepted byte of a block, carrying those four bytes.
- R3: In write mode, when a block ends after 1, 2 or 3 bytes of a word, that partial word is written in the cycle after the last byte, with its unused upper lanes zero. The next block then starts again at lane 0.
- R4: In read mode, a new port word is fetched (read strobe high for one cycle, data sampled at that clock edge) only after all four bytes of the previous word have been handed out. No byte is offered while a fetch is pending.
- R5: In read mode, at the end of a block the unused upper lanes of its last word are discarded. The next block's first byte comes from a fresh fetch, so each block uses exactly ceil(length/4) fetches.
- R6: Each block starts only when the readiness flag for the current direction is high. While waiting, the block does not accept input bytes, offer output bytes or fetch. Write mode uses wr_room_present, read mode uses rd_data_present. In write mode there is never a read strobe, and in read mode never an input-ready.
- R7: After the programmed number of blocks, done is high for exactly one cycle and busy falls in the same cycle.
- R8: Block length and block count are latched at start. Later changes on those inputs have no effect on the running transfer.
- R9: A start with a length of zero or a count of zero raises done in the next cycle. It causes no stream or port activity, and busy stays low.
- R10: While reset is held, and right after it, busy, done, the strobes, in_ready and out_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Opens a transfer when idle |
| xfer_read | input | 1 | 1 = read (port to stream), 0 = write (stream to port) |
| blk_bytes | input | 12 | Block length in bytes, 1..2048 |
| blk_total | input | 16 | Number of blocks |
| rd_data_present | input | 1 | Readiness flag for reads |
| wr_room_present | input | 1 | Readiness flag for writes |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte taken |
| out_byte | output | 8 | Output byte |
| port_wr_stb | output | 1 | One-cycle port write strobe |
| port_wr_word | output | 32 | Word written to the port |
| port_rd_stb | output | 1 | One-cycle port read strobe |
| port_rd_word | input | 32 | Port word, sampled when port_rd_stb is high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bound assertions check, on every cycle, the rules that hold at any single moment:
- every write strobe follows an accepted byte;
- no fetch is issued while a byte is still on offer;
- the idle block is silent and never drives both directions at once;
- busy only falls together with done.

Lane placement, zero padding of partial words, the discarding of unused read lanes, per-block flag gating and the latching of length and count depend on whole sequences. Only the bench's sweeps over many lengths and counts can show these, by comparing every word and byte against values it computes arithmetically.

// File: rtl/pio_pkg.sv
// Shared constants and types for the PIO byte/word packer.
// Assumes a 32-bit port made of four byte lanes.
package pio_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_MOVE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pio_blk_seq.sv
// Block sequencer: latches length and count at start, gates each block on
// the direction's readiness flag, counts bytes within a block and blocks
// within the transfer. Assumes byte_fire only occurs while moving.
module pio_blk_seq #(
    parameter int MAX_BLK_BYTES = 2048,
    parameter int CNT_W         = 16,
    localparam int SZ_W         = $clog2(MAX_BLK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_rd_in,
    input  logic [SZ_W-1:0]  size_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             rd_flag,
    input  logic             wr_flag,
    input  logic             byte_fire,
    output logic             moving,
    output logic             is_rd,
    output logic             last_byte,
    output logic             busy,
    output logic             done
);
    import pio_pkg::*;

    seq_state_t       state;
    logic [SZ_W-1:0]  size_q;
    logic [SZ_W-1:0]  bytes_left;
    logic [CNT_W-1:0] blocks_left;
    logic             flag_ok;

    // Pick the readiness flag for the latched direction.
    always_comb flag_ok = is_rd ? rd_flag : wr_flag;

    // Sequencer state, counters and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            is_rd       <= 1'b0;
            size_q      <= '0;
            bytes_left  <= '0;
            blocks_left <= '0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        is_rd       <= dir_rd_in;
                        size_q      <= size_in;
                        blocks_left <= count_in;
                        if (size_in == '0 || count_in == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= SEQ_WAIT;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (flag_ok) begin
                        bytes_left <= size_q;
                        state      <= SEQ_MOVE;
                    end
                end
                SEQ_MOVE: begin
                    if (byte_fire) begin
                        bytes_left <= bytes_left - SZ_W'(1);
                        if (last_byte) begin
                            blocks_left <= blocks_left - CNT_W'(1);
                            if (blocks_left == CNT_W'(1)) begin
                                state <= SEQ_IDLE;
                                done  <= 1'b1;
                            end else begin
                                state <= SEQ_WAIT;
                            end
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Status decoded from the state and byte counter.
    always_comb begin
        moving    = (state == SEQ_MOVE);
        busy      = (state != SEQ_IDLE);
        last_byte = (bytes_left == SZ_W'(1));
    end
endmodule

// File: rtl/pio_wr_pack.sv
// Write packer: places each accepted byte in the next lane of a scratch
// word and emits the word after four bytes or at the last byte of a block.
// Assumes the scratch word's unused lanes are zero between emissions.
module pio_wr_pack (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fire,
    input  logic                        last,
    input  logic [pio_pkg::BYTE_W-1:0]  data_in,
    output logic                        wr_stb,
    output logic [pio_pkg::WORD_W-1:0]  wr_word
);
    import pio_pkg::*;

    logic [WORD_W-1:0] scratch;
    logic [WORD_W-1:0] merged;
    logic [LANE_W-1:0] lane;

    // Insert the incoming byte at the current lane, one mux per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(l)) ? data_in : scratch[l*BYTE_W +: BYTE_W];
    end

    // Collect bytes and emit a full or block-final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch <= '0;
            lane    <= '0;
            wr_stb  <= 1'b0;
            wr_word <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (fire) begin
                if (lane == LANE_W'(LANES - 1) || last) begin
                    wr_word <= merged;
                    wr_stb  <= 1'b1;
                    scratch <= '0;
                    lane    <= '0;
                end else begin
                    scratch <= merged;
                    lane    <= lane + LANE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pio_rd_unpack.sv
// Read unpacker: fetches a port word when no bytes remain, then offers its
// bytes lowest lane first. Leftover lanes are dropped at a block's end.
// Assumes the port word is valid in the cycle the read strobe is high.
module pio_rd_unpack (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active,
    input  logic                        fire,
    input  logic                        last,
    input  logic [pio_pkg::WORD_W-1:0]  rd_word,
    output logic                        rd_stb,
    output logic                        out_valid,
    output logic [pio_pkg::BYTE_W-1:0]  out_byte
);
    import pio_pkg::*;

    logic [WORD_W-1:0] word_q;
    logic [LANE_W:0]   have;

    // Fetch when empty, otherwise offer the low lane.
    always_comb begin
        rd_stb    = active && (have == '0);
        out_valid = active && (have != '0);
        out_byte  = word_q[BYTE_W-1:0];
    end

    // Hold the fetched word and shift out one byte per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            have   <= '0;
        end else if (rd_stb) begin
            word_q <= rd_word;
            have   <= (LANE_W + 1)'(LANES);
        end else if (fire) begin
            word_q <= word_q >> BYTE_W;
            have   <= last ? '0 : have - (LANE_W + 1)'(1);
        end
    end
endmodule

// File: rtl/pio_word_packer.sv
// Top: block-oriented PIO transfer between a byte stream and a 32-bit data
// port. Direction, block length and block count are latched at start.
// Assumes blk_bytes never exceeds MAX_BLK_BYTES.
module pio_word_packer #(
    parameter int MAX_BLK_BYTES = 2048,
    parameter int CNT_W         = 16,
    localparam int SZ_W         = $clog2(MAX_BLK_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       xfer_read,
    input  logic [SZ_W-1:0]            blk_bytes,
    input  logic [CNT_W-1:0]           blk_total,
    input  logic                       rd_data_present,
    input  logic                       wr_room_present,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [pio_pkg::BYTE_W-1:0] in_byte,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [pio_pkg::BYTE_W-1:0] out_byte,
    output logic                       port_wr_stb,
    output logic [pio_pkg::WORD_W-1:0] port_wr_word,
    output logic                       port_rd_stb,
    input  logic [pio_pkg::WORD_W-1:0] port_rd_word,
    output logic                       busy,
    output logic                       done
);
    logic moving;
    logic is_rd;
    logic last_byte;
    logic byte_fire;
    logic wr_fire;
    logic rd_fire;
    logic rd_active;

    // Handshakes for each direction and the shared byte event.
    always_comb begin
        in_ready  = moving && !is_rd;
        rd_active = moving && is_rd;
        wr_fire   = in_valid && in_ready;
        rd_fire   = out_valid && out_ready;
        byte_fire = wr_fire || rd_fire;
    end

    pio_blk_seq #(
        .MAX_BLK_BYTES (MAX_BLK_BYTES),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir_rd_in (xfer_read),
        .size_in   (blk_bytes),
        .count_in  (blk_total),
        .rd_flag   (rd_data_present),
        .wr_flag   (wr_room_present),
        .byte_fire (byte_fire),
        .moving    (moving),
        .is_rd     (is_rd),
        .last_byte (last_byte),
        .busy      (busy),
        .done      (done)
    );

    pio_wr_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wr_fire),
        .last    (last_byte),
        .data_in (in_byte),
        .wr_stb  (port_wr_stb),
        .wr_word (port_wr_word)
    );

    pio_rd_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (rd_active),
        .fire      (rd_fire),
        .last      (last_byte),
        .rd_word   (port_rd_word),
        .rd_stb    (port_rd_stb),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );
endmodule

// File: rtl/pio_word_packer_chk.sv
// Checker for pio_word_packer: per-cycle protocol rules, bound to the top.
module pio_word_packer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic port_wr_stb,
    input logic port_rd_stb
);
    // R2: a port write always follows an accepted input byte.
    a_r2_wr_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_stb |-> $past(in_valid && in_ready));

    // R4: never fetch while a byte is still offered.
    a_r4_no_fetch_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd_stb && out_valid));

    // R6: idle means no stream or fetch activity.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(in_ready || out_valid || port_rd_stb));

    // R6: only one direction is ever active.
    a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && (out_valid || port_rd_stb)));

    // R7: busy only ends together with done.
    a_r7_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: the cycle after reset is silent.
    a_r10_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !(busy || done || port_wr_stb));
endmodule

bind pio_word_packer pio_word_packer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .port_wr_stb (port_wr_stb),
    .port_rd_stb (port_rd_stb)
);

// File: tb/pio_word_packer_bench.sv
`timescale 1ns/1ps
module pio_word_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        xfer_read = 1'b0;
    logic [11:0] blk_bytes = '0;
    logic [15:0] blk_total = '0;
    logic        rd_data_present = 1'b1;
    logic        wr_room_present = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        port_wr_stb;
    logic [31:0] port_wr_word;
    logic        port_rd_stb;
    logic [31:0] port_rd_word;
    logic        busy;
    logic        done;

    always #4 clk = ~clk;

    pio_word_packer u_pio_word_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_read(xfer_read),
        .blk_bytes(blk_bytes), .blk_total(blk_total),
        .rd_data_present(rd_data_present), .wr_room_present(wr_room_present),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .port_wr_stb(port_wr_stb), .port_wr_word(port_wr_word),
        .port_rd_stb(port_rd_stb), .port_rd_word(port_rd_word),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] src_byte(int b, int i);
        return 8'((b * 37 + i * 5 + 3) & 255);
    endfunction

    function automatic logic [31:0] port_word(int w);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = 8'((w * 11 + l * 3 + 1) & 255);
        return r;
    endfunction

    // Port model: read data follows the fetch index.
    int fetch_idx = 0;
    assign port_rd_word = port_word(fetch_idx);
    always @(posedge clk) if (port_rd_stb) fetch_idx <= fetch_idx + 1;

    // Transfer description shared with the monitor (written by the stimulus only).
    int cur_size = 1;
    int cur_wpb = 1;
    int wr_base = 0;
    int rd_base = 0;
    int fetch_base = 0;

    // Monitor: checks every port write and every output byte.
    int mon_checks = 0;
    int mon_fail = 0;
    int wr_words = 0;
    int rd_bytes = 0;
    int mon_cyc = 0;
    always @(negedge clk) begin
        mon_cyc = mon_cyc + 1;
        out_ready = (mon_cyc % 4) != 3;
        if (port_wr_stb) begin
            int n, b, w, i;
            logic [31:0] exp;
            n = wr_words - wr_base;
            b = n / cur_wpb;
            w = n % cur_wpb;
            for (int l = 0; l < 4; l++) begin
                i = 4 * w + l;
                exp[l*8 +: 8] = (i < cur_size) ? src_byte(b, i) : 8'h00;
            end
            mon_checks = mon_checks + 1;
            if (port_wr_word !== exp) begin
                mon_fail = mon_fail + 1;
                $display("FAIL R1/R2/R3 write word %0d: actual %h expected %h", n, port_wr_word, exp);
            end
            wr_words = wr_words + 1;
        end
        if (out_valid && out_ready) begin
            int n, b, i, wd;
            logic [7:0] exp;
            n = rd_bytes - rd_base;
            b = n / cur_size;
            i = n % cur_size;
            wd = fetch_base + b * cur_wpb + i / 4;
            exp = 8'((wd * 11 + (i % 4) * 3 + 1) & 255);
            mon_checks = mon_checks + 1;
            if (out_byte !== exp) begin
                mon_fail = mon_fail + 1;
                $display("FAIL R1/R4/R5 read byte %0d: actual %h expected %h", n, out_byte, exp);
            end
            rd_bytes = rd_bytes + 1;
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks + mon_checks, n_fail + mon_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    int wd_cyc = 0;
    always @(posedge clk) begin
        wd_cyc <= wd_cyc + 1;
        if (wd_cyc > 150000) begin
            $display("FAIL watchdog: actual %0d expected below 150000", wd_cyc);
            n_fail = n_fail + 1;
            finish_run();
        end
    end

    // Feed the write stream, with bubbles and an optional gap after block 0.
    task automatic feed(input int size, input int count, input bit gap);
        for (int b = 0; b < count; b++) begin
            for (int i = 0; i < size; i++) begin
                if (i % 3 == 2) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                while (!in_ready) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_byte  = src_byte(b, i);
                @(negedge clk);
                in_valid = 1'b0;
                if (gap && b == 0 && i == size - 1 && count > 1) begin
                    wr_room_present = 1'b0;
                    for (int k = 0; k < 5; k++) begin
                        chk(!in_ready, "R6 no input while next block waits", int'(in_ready), 0);
                        @(negedge clk);
                    end
                    wr_room_present = 1'b1;
                end
            end
        end
    endtask

    task automatic run_xfer(input bit rd, input int size, input int count,
                            input int flag_delay, input bit gap);
        int wr0, rd0, f0, lim;
        cur_size   = (size == 0) ? 1 : size;
        cur_wpb    = (cur_size + 3) / 4;
        wr_base    = wr_words;
        rd_base    = rd_bytes;
        fetch_base = fetch_idx;
        wr0 = wr_words; rd0 = rd_bytes; f0 = fetch_idx;
        if (flag_delay > 0) begin
            rd_data_present = 1'b0;
            wr_room_present = 1'b0;
        end
        xfer_read = rd;
        blk_bytes = 12'(size);
        blk_total = 16'(count);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        blk_bytes = 12'(size + 3);   // R8: later changes must not matter
        blk_total = 16'(count + 2);
        if (size == 0 || count == 0) begin
            chk(done && !busy, "R9 immediate done for empty transfer", int'(done), 1);
            @(negedge clk);
            chk(!done && !busy, "R9 done single pulse", int'(done), 0);
            chk(wr_words == wr0 && rd_bytes == rd0 && fetch_idx == f0,
                "R9 no activity for empty transfer", wr_words + rd_bytes + fetch_idx - wr0 - rd0 - f0, 0);
            return;
        end
        chk(busy, "R7 busy after start", int'(busy), 1);
        if (flag_delay > 0) begin
            for (int k = 0; k < flag_delay; k++) begin
                chk(!in_ready && !out_valid && !port_rd_stb, "R6 idle until flag",
                    int'(in_ready) + int'(out_valid) + int'(port_rd_stb), 0);
                @(negedge clk);
            end
            rd_data_present = 1'b1;
            wr_room_present = 1'b1;
        end
        if (!rd) feed(size, count, gap);
        lim = 0;
        while (!done && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        chk(done && !busy, "R7 done with busy low", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R7 done lasts one cycle", int'(done), 0);
        if (rd) begin
            chk(rd_bytes - rd0 == size * count, "R8 read byte count", rd_bytes - rd0, size * count);
            chk(fetch_idx - f0 == cur_wpb * count, "R5 fetches per transfer", fetch_idx - f0, cur_wpb * count);
            chk(wr_words == wr0, "R6 no write strobe in read mode", wr_words - wr0, 0);
        end else begin
            chk(wr_words - wr0 == cur_wpb * count, "R3 words per transfer", wr_words - wr0, cur_wpb * count);
            chk(fetch_idx == f0, "R6 no fetch in write mode", fetch_idx - f0, 0);
        end
    endtask

    int sizes[9] = '{1, 2, 3, 4, 5, 6, 7, 8, 13};

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !in_ready && !out_valid && !port_wr_stb && !port_rd_stb,
            "R10 quiet in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !in_ready && !out_valid && !port_wr_stb && !port_rd_stb,
            "R10 quiet after reset", int'(busy), 0);
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 9; s++)
                for (int c = 1; c <= 3; c += 2)
                    run_xfer(d[0], sizes[s], c, 0, 1'b0);
        run_xfer(1'b0, 6, 3, 0, 1'b1);      // R6 gap between blocks
        run_xfer(1'b0, 5, 1, 6, 1'b0);      // R6 write waits for room
        run_xfer(1'b1, 7, 2, 6, 1'b0);      // R6 read waits for data
        run_xfer(1'b0, 0, 3, 0, 1'b0);      // R9 zero length
        run_xfer(1'b1, 4, 0, 0, 1'b0);      // R9 zero count
        run_xfer(1'b1, 2048, 1, 0, 1'b0);   // R5 largest block
        run_xfer(1'b0, 2047, 1, 0, 1'b0);   // R3 largest partial block
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule